// File: doc/BRIEF.md
# I2C Controller Interrupt and DMA-Request Logic

This block is the event-reporting part of a memory-mapped I2C master controller. It keeps the event status bits that the transfer engine raises, the interrupt-enable bits set by software, and the two DMA-enable bits. From these it drives one combined interrupt line and two DMA request lines, one for receive and one for transmit. The transfer engine and the data FIFO are outside this block. They connect to it only through per-bit set and clear pulses and a live bus-busy level.

A revision parameter picks one of two ways for software to clear status. On the legacy variant, a vector register returns the position of the lowest pending, enabled event, counted from 1. Reading it also clears that one status bit. On the newer variant (revision code 0x34 or higher) that register reads as zero. Software then clears status by writing ones, and it can only clear the bits it owns. The newer variant also has a self-test write that forces the six low event bits high.

The register word addresses are 0 for interrupt enable, 1 for status, 2 for the vector, 3 for the DMA configuration and 4 for the self-test register. Read data is registered. It appears on `rd_data` the cycle after `rd_en` and is zero in every cycle that follows no read.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when status AND enable is non-zero. It changes on the same clock edge as the status and enable registers it depends on.
- R2: The DMA configuration keeps only bit 15 (receive DMA on) and bit 7 (transmit DMA on). A write with bit 15 at 1 clears enable bit 3. A write with bit 7 at 1 clears enable bit 4.
- R3: `rx_drq` equals receive-DMA-on AND status bit 3. `tx_drq` equals transmit-DMA-on AND status bit 4. Each is low while its DMA bit is off.
- R4: On the legacy variant, a read of address 2 returns (index+1) of the lowest set bit of status AND enable, or 0 if none is set. The same read clears that one status bit.
- R5: On the newer variant, address 2 reads 0 and changes nothing. A write to address 1 clears the status bits set in (wdata AND 0x0027). Bits 3 and 4 cannot be cleared by software.
- R6: On the legacy variant, writes to address 1 have no effect.
- R7: The enable register keeps wdata AND 0x001F on the legacy variant and wdata AND 0x003F on the newer one.
- R8: Status reads show stored bits 0 to 5, 10, 11 and 15. Bit 12 shows the live `bus_busy` level and is not stored. All other bits read 0. Bit 3 is receive-ready and bit 4 is transmit-ready.
- R9: On the newer variant, a write to address 4 with bit 11 at 1 sets status bits 0 to 5. On the legacy variant this write does nothing.
- R10: When a set pulse and any clear of the same status bit fall in the same cycle, the bit ends up set.
- R11: After reset, status, enable, DMA configuration, `irq`, `rx_drq`, `tx_drq` and `rd_data` are all 0.
- R12: A pulse on `evt_clr[i]` clears stored status bit i on the next edge. This is how the receive-ready and transmit-ready bits are cleared.
- R13: Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| evt_set | input | 16 | Per-bit status set pulses from the transfer engine |
| evt_clr | input | 16 | Per-bit status clear pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Combined interrupt |
| rx_drq | output | 1 | Receive DMA request |
| tx_drq | output | 1 | Transmit DMA request |

## Verification
The bench drives both variants side by side and aims at the points where the two differ. Some writes must be ignored: a legacy design that honoured status writes would drop pending events. Clears must be restricted: a newer design that let software clear bit 3 or 4 would lose DMA requests. The vector read is exercised with several events pending at once. A wrong priority, or clearing more than one bit, would show up in the next vector value and in `irq`. The bench also puts a set pulse and a clear of the same bit in one cycle, and writes DMA enables while the ready interrupts are enabled. A design in which the clear won, or in which the ready interrupt stayed enabled next to DMA, would give the wrong `irq` or status.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt/DMA-request block.
// Assumes a 16-bit register data path and eight word addresses.
package i2c_irq_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_EN   = 3'd0,
        A_STATUS   = 3'd1,
        A_VECTOR   = 3'd2,
        A_DMA_CFG  = 3'd3,
        A_SELFTEST = 3'd4
    } reg_addr_e;

    localparam int B_RX_RDY  = 3;
    localparam int B_TX_RDY  = 4;
    localparam int B_BUSY    = 12;
    localparam int B_RX_DMA  = 15;
    localparam int B_TX_DMA  = 7;
    localparam int B_FORCE   = 11;

    localparam logic [DATA_W-1:0] STORED_MASK = 16'h8C3F;
    localparam logic [DATA_W-1:0] SW_CLR_MASK = 16'h0027;
    localparam logic [DATA_W-1:0] FORCE_MASK  = 16'h003F;
    localparam logic [DATA_W-1:0] DMA_MASK    = 16'h8080;
    localparam logic [7:0]        NEW_REV_MIN = 8'h34;
endpackage

// File: rtl/i2c_irq_status.sv
// Status register. It merges set pulses, the three clear sources and the
// forced set into the stored bits. Set always wins over clear.
// Assumes: the clear inputs are already qualified by the variant.
module i2c_irq_status #(
    parameter int W = 16,
    parameter logic [W-1:0] KEEP = '1,
    parameter int RX_BIT = 3,
    parameter int TX_BIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_set,
    input  logic [W-1:0] evt_clr,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] vec_clr,
    input  logic [W-1:0] force_set,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    logic [W-1:0] all_clr;

    // Combine every clear source, then apply sets on top.
    always_comb begin
        all_clr = evt_clr | sw_clr | vec_clr;
        stat_d  = ((stat_q & ~all_clr) | evt_set | force_set) & KEEP;
    end

    // Status storage.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // R10: a set pulse of a stored bit is visible after the edge.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & KEEP) != '0) |=> ((stat_q & $past(evt_set & KEEP)) == $past(evt_set & KEEP)));

    // R5: software cannot clear the ready bits.
    p_rdy_hw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[RX_BIT] && !evt_clr[RX_BIT] && !vec_clr[RX_BIT]) |=> stat_q[RX_BIT]);
    p_txrdy_hw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[TX_BIT] && !evt_clr[TX_BIT] && !vec_clr[TX_BIT]) |=> stat_q[TX_BIT]);
endmodule

// File: rtl/i2c_irq_prio.sv
// Lowest-bit-first priority encoder for the vector register.
// Returns the 1-based position of the lowest set bit, or 0 if none is set,
// and a one-hot mask of that bit.
module i2c_irq_prio #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     pend,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     first
);
    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        idx   = '0;
        first = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx      = IDX_W'(i + 1);
                first    = '0;
                first[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_out.sv
// Registered interrupt and DMA-request outputs. They are taken from the
// next-state values, so they change on the same edge as the registers.
module i2c_irq_out #(
    parameter int W = 16,
    parameter int RX_BIT = 3,
    parameter int TX_BIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_d,
    input  logic [W-1:0] en_d,
    input  logic         rx_dma_d,
    input  logic         tx_dma_d,
    output logic         irq,
    output logic         rx_drq,
    output logic         tx_drq
);
    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            rx_drq <= 1'b0;
            tx_drq <= 1'b0;
        end else begin
            irq    <= |(stat_d & en_d);
            rx_drq <= rx_dma_d & stat_d[RX_BIT];
            tx_drq <= tx_dma_d & stat_d[TX_BIT];
        end
    end
endmodule

// File: rtl/i2c_irq_ctrl.sv
// Top level of the I2C interrupt/DMA-request logic. It decodes register
// accesses, holds the enable and DMA configuration, and selects the
// variant-specific clear paths.
// Assumes: at most one read and one write per cycle, single-cycle strobes.
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter logic [7:0] REV = 8'h10,
    localparam bit NEW_REV = (REV >= NEW_REV_MIN),
    localparam logic [DATA_W-1:0] EN_MASK = NEW_REV ? 16'h003F : 16'h001F,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_set,
    input  logic [DATA_W-1:0] evt_clr,
    input  logic              bus_busy,
    output logic              irq,
    output logic              rx_drq,
    output logic              tx_drq
);
    logic [DATA_W-1:0] stat_q, stat_d, en_q, en_d;
    logic              rx_dma_q, tx_dma_q, rx_dma_d, tx_dma_d;
    logic [DATA_W-1:0] sw_clr, vec_clr, force_set, first;
    logic [IDX_W-1:0]  vec_idx;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_en_reg, wr_dma, wr_stat, wr_test, rd_vec;

    // Address decode.
    always_comb begin
        wr_en_reg = wr_en && (addr == A_IRQ_EN);
        wr_dma    = wr_en && (addr == A_DMA_CFG);
        wr_stat   = wr_en && (addr == A_STATUS);
        wr_test   = wr_en && (addr == A_SELFTEST);
        rd_vec    = rd_en && (addr == A_VECTOR);
    end

    i2c_irq_prio #(.W(DATA_W)) u_prio (
        .pend  (stat_q & en_q),
        .idx   (vec_idx),
        .first (first)
    );

    // The variant decides which software clear path exists.
    generate
        if (NEW_REV) begin : g_w1c
            assign sw_clr    = wr_stat ? (wdata & SW_CLR_MASK) : '0;
            assign force_set = (wr_test && wdata[B_FORCE]) ? FORCE_MASK : '0;
            assign vec_clr   = '0;
        end else begin : g_vector
            assign sw_clr    = '0;
            assign force_set = '0;
            assign vec_clr   = rd_vec ? first : '0;
        end
    endgenerate

    i2c_irq_status #(.W(DATA_W), .KEEP(STORED_MASK), .RX_BIT(B_RX_RDY), .TX_BIT(B_TX_RDY)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set   (evt_set),
        .evt_clr   (evt_clr),
        .sw_clr    (sw_clr),
        .vec_clr   (vec_clr),
        .force_set (force_set),
        .stat_q    (stat_q),
        .stat_d    (stat_d)
    );

    // Next state of the enable and DMA registers. A DMA enable masks its ready interrupt.
    always_comb begin
        en_d     = en_q;
        rx_dma_d = rx_dma_q;
        tx_dma_d = tx_dma_q;
        if (wr_en_reg) en_d = wdata & EN_MASK;
        if (wr_dma) begin
            rx_dma_d = wdata[B_RX_DMA];
            tx_dma_d = wdata[B_TX_DMA];
            if (wdata[B_RX_DMA]) en_d[B_RX_RDY] = 1'b0;
            if (wdata[B_TX_DMA]) en_d[B_TX_RDY] = 1'b0;
        end
    end

    // Enable and DMA configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            rx_dma_q <= 1'b0;
            tx_dma_q <= 1'b0;
        end else begin
            en_q     <= en_d;
            rx_dma_q <= rx_dma_d;
            tx_dma_q <= tx_dma_d;
        end
    end

    i2c_irq_out #(.W(DATA_W), .RX_BIT(B_RX_RDY), .TX_BIT(B_TX_RDY)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_d   (stat_d),
        .en_d     (en_d),
        .rx_dma_d (rx_dma_d),
        .tx_dma_d (tx_dma_d),
        .irq      (irq),
        .rx_drq   (rx_drq),
        .tx_drq   (tx_drq)
    );

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_IRQ_EN:  rd_mux = en_q;
            A_STATUS: begin
                rd_mux         = stat_q;
                rd_mux[B_BUSY] = bus_busy;
            end
            A_VECTOR:  rd_mux = NEW_REV ? '0 : DATA_W'(vec_idx);
            A_DMA_CFG: begin
                rd_mux[B_RX_DMA] = rx_dma_q;
                rd_mux[B_TX_DMA] = tx_dma_q;
            end
            default:   rd_mux = '0;
        endcase
    end

    // Registered read port; zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end

    // R1: the interrupt line tracks the stored status and enable.
    p_irq_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat_q & en_q));

    // R2: enabling receive DMA removes the receive-ready interrupt enable.
    p_dma_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DMA_CFG && wdata[B_RX_DMA]) |=> !en_q[B_RX_RDY]);

    // R3: the DMA requests track the ready bits while enabled.
    p_rx_drq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drq == (rx_dma_q & stat_q[B_RX_RDY]));
    p_tx_drq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drq == (tx_dma_q & stat_q[B_TX_RDY]));

    // R4: a vector read clears at most one status bit.
    p_vec_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_clr));
endmodule

// File: tb/i2c_irq_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, bus_busy = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0, evt_set = '0, evt_clr = '0;
    logic [15:0] rd_l, rd_n;
    logic        irq_l, rx_l, tx_l, irq_n, rx_n, tx_n;
    int          checks = 0, failures = 0;

    logic [15:0] m_stat [2];
    logic [15:0] m_en   [2];
    logic [15:0] m_dma  [2];

    always #2.5 clk = ~clk;

    i2c_irq_ctrl #(.REV(8'h10)) u_i2c_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_l), .evt_set(evt_set), .evt_clr(evt_clr),
        .bus_busy(bus_busy), .irq(irq_l), .rx_drq(rx_l), .tx_drq(tx_l));

    i2c_irq_ctrl #(.REV(8'h34)) u_i2c_irq_ctrl_new (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .bus_busy(bus_busy), .irq(irq_n), .rx_drq(rx_n), .tx_drq(tx_n));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of one clock edge for variant v (1 = newer revision).
    task automatic model_step(input int v, output logic [15:0] e_rd);
        logic [15:0] pend, clr, frc, vec;
        bit nw = (v == 1);
        pend = m_stat[v] & m_en[v];
        vec  = 0;
        if (!nw) for (int i = 15; i >= 0; i--) if (pend[i]) vec = 16'(i + 1);
        e_rd = 0;
        if (rd_en) case (addr)
            3'd0: e_rd = m_en[v];
            3'd1: e_rd = m_stat[v] | (16'(bus_busy) << 12);
            3'd2: e_rd = vec;
            3'd3: e_rd = m_dma[v];
            default: e_rd = 0;
        endcase
        clr = evt_clr;
        if (nw && wr_en && addr == 3'd1) clr |= wdata & 16'h0027;
        if (!nw && rd_en && addr == 3'd2 && vec != 0) clr |= 16'(1) << (vec - 1);
        frc = (nw && wr_en && addr == 3'd4 && wdata[11]) ? 16'h003F : 16'h0000;
        m_stat[v] = ((m_stat[v] & ~clr) | evt_set | frc) & 16'h8C3F;
        if (wr_en && addr == 3'd0) m_en[v] = wdata & (nw ? 16'h003F : 16'h001F);
        if (wr_en && addr == 3'd3) begin
            m_dma[v] = wdata & 16'h8080;
            if (wdata[15]) m_en[v][3] = 1'b0;
            if (wdata[7])  m_en[v][4] = 1'b0;
        end
    endtask

    // Apply the prepared inputs for one cycle and compare both variants.
    task automatic cycle(input string tag);
        logic [15:0] e0, e1;
        model_step(0, e0);
        model_step(1, e1);
        @(posedge clk);
        @(negedge clk);
        check({tag, " legacy rd"}, rd_l, e0);
        check({tag, " new rd"}, rd_n, e1);
        check("R1 legacy irq", 16'(irq_l), 16'(|(m_stat[0] & m_en[0])));
        check("R1 new irq", 16'(irq_n), 16'(|(m_stat[1] & m_en[1])));
        check("R3 legacy rx_drq", 16'(rx_l), 16'(m_dma[0][15] & m_stat[0][3]));
        check("R3 new tx_drq", 16'(tx_n), 16'(m_dma[1][7] & m_stat[1][4]));
        check("R3 legacy tx_drq", 16'(tx_l), 16'(m_dma[0][7] & m_stat[0][4]));
        check("R3 new rx_drq", 16'(rx_n), 16'(m_dma[1][15] & m_stat[1][3]));
        rd_en = 0; wr_en = 0; evt_set = 0; evt_clr = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        wr_en = 1; addr = a; wdata = d; cycle(tag);
    endtask
    task automatic rd(input logic [2:0] a, input string tag);
        rd_en = 1; addr = a; cycle(tag);
    endtask

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R8";
            3'd2: return "R4";
            3'd3: return "R2";
            default: return "R13";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int v = 0; v < 2; v++) begin m_stat[v] = 0; m_en[v] = 0; m_dma[v] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state visible through every register and output.
        check("R11 irq", 16'(irq_l | irq_n | rx_l | tx_l | rx_n | tx_n), 16'h0);
        rd(3'd0, "R11 en"); rd(3'd1, "R11 stat"); rd(3'd3, "R11 dma");
        // R7: enable width per variant.
        wr(3'd0, 16'hFFFF, "R7"); rd(3'd0, "R7 en");
        // R9: forced set on the newer variant only; R8 busy bit live.
        wr(3'd4, 16'h0800, "R9"); bus_busy = 1; rd(3'd1, "R9 R8 stat"); bus_busy = 0;
        // R5 and R6: status writes.
        wr(3'd1, 16'hFFFF, "R5 R6"); rd(3'd1, "R5 R6 stat");
        // R4: vector reads with several pending events.
        evt_set = 16'h0016; cycle("R4 setup");
        rd(3'd2, "R4 vec1"); rd(3'd2, "R4 vec2"); rd(3'd2, "R4 vec3"); rd(3'd2, "R4 vec4");
        // R10: set and clear of the same bit in one cycle.
        evt_set = 16'h0002; evt_clr = 16'h0002; cycle("R10 hw");
        evt_set = 16'h0002; wr(3'd1, 16'h0002, "R10 sw"); rd(3'd1, "R10 stat");
        evt_set = 16'h0002; rd(3'd2, "R10 vec"); rd(3'd1, "R10 stat2");
        // R12: hardware clear of the ready bits.
        evt_set = 16'h0018; cycle("R12 setup");
        evt_clr = 16'h0008; cycle("R12"); rd(3'd1, "R12 stat");
        // R2 and R3: DMA enables mask the ready interrupts and raise requests.
        evt_set = 16'h0018; wr(3'd0, 16'h003F, "R2 en"); rd(3'd0, "R2 en");
        wr(3'd3, 16'hFFFF, "R2 dma"); rd(3'd3, "R2 dma"); rd(3'd0, "R2 en masked");
        evt_clr = 16'h0018; cycle("R3 drop");
        // R13: unmapped addresses.
        wr(3'd6, 16'hFFFF, "R13"); rd(3'd7, "R13"); rd(3'd0, "R13 en");
        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            a        = 3'($urandom_range(0, 7));
            bus_busy = 1'($urandom);
            evt_set  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            evt_clr  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            wdata    = 16'($urandom);
            if ($urandom_range(0, 3) == 0) wdata[11] = 1'b0;
            addr     = a;
            case ($urandom_range(0, 2))
                0: rd_en = 1;
                1: wr_en = 1;
                default: ;
            endcase
            cycle(rd_tag(a));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule